// File: doc/BRIEF.md
# Programmable Countdown Timer with Rate Select

This block is a periodic countdown timer. A 12-bit start value is assembled from two byte-wide preset fields. While the timer is enabled, it counts down at one of four source rates: 4096 Hz, 64 Hz, 1 Hz or once per minute. When a count runs out, it raises a sticky expiry flag and, if the interrupt is unmasked, an interrupt request. The counter then reloads itself and keeps going, so expiries repeat for as long as the timer stays enabled.

The four source rates come from an internal prescaler chain. The chain is fed by a single-cycle enable pulse at the 32768 Hz base rate. Each stage divides by its own parameter, so a fast simulation can shrink the chain without touching the logic.

All pins are plain level-sensitive controls and status. No data stream crosses the edge of the block, so there is no valid/ready handshake. Preset and select inputs are sampled whenever a load happens.

Top module: `cdt_top`

## Requirements
- R1: The 12-bit start value is formed with `preset_lo_i[7:0]` as bits 7..0 and `preset_hi_i[3:0]` as bits 11..8.
- R2: `sel_i` picks the source tick: 2'b00 gives 64 Hz, 2'b01 gives 1 Hz, 2'b10 gives the once-per-minute tick, and 2'b11 gives 4096 Hz.
- R3: With start value N, the first expiry comes exactly (N+1) source periods after the enabling clock edge. N=0 therefore expires after one period.
- R4: `flag_o` is set by an expiry and stays set until `flag_clr_i` is high at a clock edge with no expiry. When an expiry and a clear meet on the same edge, the expiry wins.
- R5: `irq_o` is high exactly while `flag_o` and `tie_i` are both high.
- R6: While `ten_i` is low, the count and prescaler phase make no progress and no expiry occurs.
- R7: When `ten_i` goes from low to high, the counter loads the start value and the prescaler phase restarts. The first period after enabling is therefore always a full one.
- R8: At each expiry the counter reloads the start value, so expiries repeat every (N+1) source periods while enabled.
- R9: After reset, `flag_o` and `irq_o` are low.
- R10: Prescaler stages divide the base tick by `DIV_4K`, then `DIV_64`, then `DIV_1HZ`, then `DIV_MIN`. The defaults are 8, 64, 64 and 60 from a 32768 Hz base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_tick_i | input | 1 | One-cycle pulse at the base (32768 Hz) rate |
| ten_i | input | 1 | Timer enable |
| tie_i | input | 1 | Interrupt enable |
| sel_i | input | 2 | Source rate select |
| preset_lo_i | input | 8 | Start value bits 7..0 |
| preset_hi_i | input | 4 | Start value bits 11..8 |
| flag_clr_i | input | 1 | Clear request for the expiry flag |
| flag_o | output | 1 | Sticky expiry flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is the minute source with a large start value, which would take billions of cycles at the real ratios. The bench overrides the prescaler ratios with small values, which keeps every cycle relationship intact and brings each expiry edge within reach. Holding the clear input high through a short-period expiry exercises the case where a clear meets a set on the same edge. Disabling mid-count and then re-enabling shows that the phase restarts fully, with no leftover partial period.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [1:0] {
    SEL_64HZ = 2'b00,
    SEL_1HZ  = 2'b01,
    SEL_MIN  = 2'b10,
    SEL_4KHZ = 2'b11
  } rate_sel_e;

  // index of each rate in the prescaler tick vector
  localparam int unsigned TK_4K  = 0;
  localparam int unsigned TK_64  = 1;
  localparam int unsigned TK_1HZ = 2;
  localparam int unsigned TK_MIN = 3;
  localparam int unsigned N_TICKS = 4;
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler #(
  parameter int unsigned DIV_4K  = 8,
  parameter int unsigned DIV_64  = 64,
  parameter int unsigned DIV_1HZ = 64,
  parameter int unsigned DIV_MIN = 60
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       base_tick_i,
  input  logic       restart_i,
  output logic [3:0] tick_o
);
  localparam int unsigned NSTG = cdt_pkg::N_TICKS;
  localparam int unsigned RATIO [NSTG] = '{DIV_4K, DIV_64, DIV_1HZ, DIV_MIN};

  logic [NSTG:0] chain;
  assign chain[0] = base_tick_i & ~restart_i;

  for (genvar gi = 0; gi < NSTG; gi++) begin : g_stage
    localparam int unsigned R = RATIO[gi];
    if (R <= 1) begin : g_pass
      assign chain[gi+1] = chain[gi];
    end else begin : g_div
      localparam int unsigned W = $clog2(R);
      logic [W-1:0] cnt_q;
      logic         wrap;
      assign wrap = (cnt_q == W'(R - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q <= '0;
        end else if (restart_i) begin
          cnt_q <= '0;
        end else if (chain[gi]) begin
          cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
      end
      assign chain[gi+1] = chain[gi] & wrap;
    end
  end

  assign tick_o = chain[NSTG:1];
endmodule

// File: rtl/cdt_rate_mux.sv
module cdt_rate_mux
  import cdt_pkg::*;
(
  input  logic [3:0] tick_i,
  input  rate_sel_e  sel_i,
  output logic       tick_o
);
  always_comb begin
    unique case (sel_i)
      SEL_64HZ: tick_o = tick_i[TK_64];
      SEL_1HZ:  tick_o = tick_i[TK_1HZ];
      SEL_MIN:  tick_o = tick_i[TK_MIN];
      SEL_4KHZ: tick_o = tick_i[TK_4K];
      default:  tick_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ten_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             flag_clr_i,
  output logic             flag_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             step;
  logic             expire;

  assign step   = ten_i & ~start_i & tick_i;
  assign expire = step & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= preset_i;
    end else if (step) begin
      cnt_q <= expire ? preset_i : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (flag_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cdt_top.sv
module cdt_top #(
  parameter int unsigned LO_W    = 8,
  parameter int unsigned HI_W    = 4,
  parameter int unsigned DIV_4K  = 8,
  parameter int unsigned DIV_64  = 64,
  parameter int unsigned DIV_1HZ = 64,
  parameter int unsigned DIV_MIN = 60
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            base_tick_i,
  input  logic            ten_i,
  input  logic            tie_i,
  input  logic [1:0]      sel_i,
  input  logic [LO_W-1:0] preset_lo_i,
  input  logic [HI_W-1:0] preset_hi_i,
  input  logic            flag_clr_i,
  output logic            flag_o,
  output logic            irq_o
);
  localparam int unsigned CNT_W = LO_W + HI_W;

  logic             ten_q;
  logic             start;
  logic [3:0]       ticks;
  logic             sel_tick;
  logic [CNT_W-1:0] preset;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ten_q <= 1'b0;
    else         ten_q <= ten_i;
  end

  assign start  = ten_i & ~ten_q;
  assign preset = {preset_hi_i, preset_lo_i};

  cdt_prescaler #(
    .DIV_4K (DIV_4K),
    .DIV_64 (DIV_64),
    .DIV_1HZ(DIV_1HZ),
    .DIV_MIN(DIV_MIN)
  ) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_tick_i(base_tick_i & ten_i),
    .restart_i  (start),
    .tick_o     (ticks)
  );

  cdt_rate_mux u_mux (
    .tick_i(ticks),
    .sel_i (cdt_pkg::rate_sel_e'(sel_i)),
    .tick_o(sel_tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ten_i     (ten_i),
    .start_i   (start),
    .tick_i    (sel_tick),
    .preset_i  (preset),
    .flag_clr_i(flag_clr_i),
    .flag_o    (flag_o)
  );

  assign irq_o = flag_o & tie_i;
endmodule

// File: rtl/cdt_chk.sv
module cdt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ten_i,
  input logic tie_i,
  input logic flag_clr_i,
  input logic flag_o,
  input logic irq_o
);
  // R6
  flag_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(ten_i));

  // R4
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !flag_clr_i) |=> flag_o);

  // R4
  flag_fall_by_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(flag_clr_i));

  // R5
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tie_i |-> !irq_o);

  // R5
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
endmodule

bind cdt_top cdt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ten_i     (ten_i),
  .tie_i     (tie_i),
  .flag_clr_i(flag_clr_i),
  .flag_o    (flag_o),
  .irq_o     (irq_o)
);

// File: tb/cdt_top_tb.sv
module cdt_top_tb;
  // Shrunk ratios: 4096->2, 64->8, 1Hz->32, minute->96 cycles (R10)
  localparam int unsigned D4K = 2, D64 = 4, D1 = 4, DMIN = 3;

  typedef struct packed {
    logic [1:0]  sel;
    logic [11:0] preset;
    logic        tie;
    logic [15:0] span;
  } vec_t;

  // span = (preset+1) * source period in cycles (R2, R3)
  localparam vec_t VEC [5] = '{
    '{2'b01, 12'd5,    1'b1, 16'd192},
    '{2'b00, 12'd320,  1'b1, 16'd2568},
    '{2'b11, 12'd4095, 1'b0, 16'd8192},
    '{2'b10, 12'd1,    1'b1, 16'd192},
    '{2'b00, 12'd0,    1'b1, 16'd8}
  };

  logic clk = 0, rst_n = 0;
  logic ten = 0, tie = 0, clr = 0;
  logic [1:0] sel = 0;
  logic [7:0] plo = 0;
  logic [3:0] phi = 0;
  logic flag, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cdt_top #(.DIV_4K(D4K), .DIV_64(D64), .DIV_1HZ(D1), .DIV_MIN(DMIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .base_tick_i(1'b1), .ten_i(ten), .tie_i(tie),
    .sel_i(sel), .preset_lo_i(plo), .preset_hi_i(phi), .flag_clr_i(clr),
    .flag_o(flag), .irq_o(irq));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clear_flag();
    clr = 1; step(1); clr = 0;
  endtask

  task automatic arm(input logic [1:0] s, input logic [11:0] p, input logic ie);
    ten = 0; sel = s; plo = p[7:0]; phi = p[11:8]; tie = ie;
    clear_flag();
    ten = 1; step(1);   // state after the enabling edge (k=0)
  endtask

  initial begin
    step(3);
    // R9 reset state
    chk("R9 flag", flag, 1'b0);
    chk("R9 irq", irq, 1'b0);
    rst_n = 1; step(1);

    // vector table: R1, R2, R3, R5
    for (int i = 0; i < 5; i++) begin
      arm(VEC[i].sel, VEC[i].preset, VEC[i].tie);
      step(int'(VEC[i].span) - 1);
      chk("R3 no early expiry", flag, 1'b0);
      chk("R5 irq idle", irq, 1'b0);
      step(1);
      chk("R3/R2/R1 expiry", flag, 1'b1);
      chk("R5 irq gating", irq, VEC[i].tie);
    end

    // R5: unmask after expiry raises irq
    tie = 1; #1;
    chk("R5 irq on unmask", irq, 1'b1);

    // R8: repeat after reload (1 Hz, preset 2 -> 96 cycles)
    arm(2'b01, 12'd2, 1'b1);
    step(95);
    chk("R8 first clear", flag, 1'b0);
    step(1);
    chk("R8 first set", flag, 1'b1);
    clear_flag();          // k = 97
    chk("R4 clear", flag, 1'b0);
    step(94);              // k = 191
    chk("R8 second clear", flag, 1'b0);
    step(1);
    chk("R8 second set", flag, 1'b1);

    // R6/R7: disable mid-count, hold, re-enable restarts full span
    arm(2'b01, 12'd2, 1'b1);
    step(60);
    ten = 0; step(300);
    chk("R6 no expiry while disabled", flag, 1'b0);
    ten = 1; step(1);
    step(95);
    chk("R7 full first span", flag, 1'b0);
    step(1);
    chk("R7 expiry after restart", flag, 1'b1);

    // R4: expiry wins over clear on the same edge (4096 Hz, preset 0 -> 2)
    arm(2'b11, 12'd0, 1'b0);
    clr = 1;
    step(1);               // k = 1
    chk("R4 no set yet", flag, 1'b0);
    step(1);               // k = 2, expiry edge with clr high
    chk("R4 set beats clear", flag, 1'b1);
    step(1);               // k = 3, clear only
    chk("R4 clear next edge", flag, 1'b0);
    clr = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule